// File: doc/BRIEF.md
# Receive VLAN Tag Stripper

This block sits in the byte-wide receive path of an Ethernet frame parser. Frames enter as a valid/ready byte stream with start-of-frame and end-of-frame markers. The block watches the two bytes that follow the 12 address bytes. When those bytes carry the VLAN type value and stripping is permitted, the four tag bytes are cut out of the stream and the 16-bit tag control word is handed back as sideband data alongside the frame's last byte. All other frames leave the block byte for byte as they arrived.

Stripping is permitted only when three configuration inputs agree: the enable is set, the parse-depth value is non-zero, and the layer-2 offset value is zero. The block samples these inputs on the start-of-frame byte, so a frame is handled under one setting from start to end. A small holding queue keeps the candidate tag bytes, and the address byte before them, until the block knows whether to drop them. The input therefore keeps moving unless the output side applies back-pressure.

Top module: `vlan_tag_stripper`

## Requirements
- R1: With `cfg_strip_en` low at the start-of-frame byte, the frame leaves unchanged, even when it carries a tag, and `out_tag_found` is 0.
- R2: A frame of at least 17 bytes whose bytes 12 and 13 (counting from 0) are 0x81 then 0x00 has bytes 12 to 15 removed when stripping is permitted. All other bytes leave in their original order, with the start marker on the first byte and the end marker on the last.
- R3: A parse-depth value of zero at the start-of-frame byte disables stripping for that frame.
- R4: A non-zero layer-2 offset value at the start-of-frame byte disables stripping for that frame.
- R5: `out_meta_valid` is high only on the output byte carrying the end marker. On that byte, `out_tag_found` tells whether the tag was removed. `out_tag_ctrl` is then byte 14 as the high half and byte 15 as the low half, and it is 0 when no tag was removed.
- R6: A frame whose bytes 12 and 13 are not 0x81, 0x00 leaves unchanged with `out_tag_found` 0.
- R7: A frame shorter than 16 bytes leaves unchanged with `out_tag_found` 0, even if its bytes 12 and 13 are 0x81, 0x00.
- R8: Configuration changes after the start-of-frame byte has been accepted do not affect that frame.
- R9: The value 0x81, 0x00 at any position other than bytes 12 and 13 does not cause removal.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1. A byte offered on the output and not taken stays valid and unchanged. No byte is lost or duplicated under back-pressure or input gaps, including back-to-back short frames.
- R11: A 16-byte frame with a tag and stripping permitted leaves as its first 12 bytes, with the end marker and the sideband on byte 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_strip_en | input | 1 | Tag stripping enable |
| cfg_parse_depth | input | PD_W | Parse depth; zero disables stripping |
| cfg_l2_offset | input | OFS_W | Layer-2 offset; non-zero disables stripping |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Input byte is the first of a frame |
| in_eof | input | 1 | Input byte is the last of a frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | Output byte is the first of a frame |
| out_eof | output | 1 | Output byte is the last of a frame |
| out_meta_valid | output | 1 | Per-frame sideband valid, with the last byte |
| out_tag_found | output | 1 | Tag was removed from this frame |
| out_tag_ctrl | output | 16 | Removed tag control word, or 0 |

## Verification
The bench builds the block with its defaults: a six-entry holding queue, a 2-bit parse depth and a 5-bit offset. At these sizes every frame length from 1 to 40 bytes can be swept, tagged and untagged. That sweep crosses each edge of the tag window, and a short or exactly 16-byte frame ends inside the held bytes. The full grid of enable, all four parse depths and three offsets is also small enough to cover entirely. Pseudo-random stalls on both sides fill the six-entry queue often, so stalled output, held tag bytes and back-to-back short frames meet while the previous frame's end marker is still queued.

// File: rtl/vlan_tag_stripper.sv
module vlan_tag_stripper #(
  parameter int DEPTH = 6,
  parameter int PD_W  = 2,
  parameter int OFS_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_strip_en,
  input  logic [PD_W-1:0]  cfg_parse_depth,
  input  logic [OFS_W-1:0] cfg_l2_offset,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_sof,
  output logic             out_eof,
  output logic             out_meta_valid,
  output logic             out_tag_found,
  output logic [15:0]      out_tag_ctrl
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = 5;
  localparam logic [PW-1:0] P_WIN   = PW'(11);
  localparam logic [PW-1:0] P_TYPEH = PW'(12);
  localparam logic [PW-1:0] P_TYPEL = PW'(13);
  localparam logic [PW-1:0] P_CTRLH = PW'(14);
  localparam logic [PW-1:0] P_LAST  = PW'(15);
  localparam logic [PW-1:0] P_SAT   = PW'(16);
  localparam logic [7:0]    TPID_H  = 8'h81;
  localparam logic [7:0]    TPID_L  = 8'h00;

  logic [CW-1:0]    cnt;
  logic [7:0]       q_data [DEPTH];
  logic [2:0]       q_k    [DEPTH];
  logic [DEPTH-1:0] q_sof, q_eof, q_rel, q_drop, q_tf;

  logic [7:0]       m_data [DEPTH];
  logic [2:0]       m_k    [DEPTH];
  logic [DEPTH-1:0] m_sof, m_eof, m_rel, m_drop, m_tf;

  logic [7:0]       n_data [DEPTH];
  logic [2:0]       n_k    [DEPTH];
  logic [DEPTH-1:0] n_sof, n_eof, n_rel, n_drop, n_tf;

  logic [PW-1:0] pos_q, pos_cur;
  logic          allow_q, frame_tag_q;
  logic [7:0]    type_h, type_l, ctrl_h;
  logic [15:0]   ctrl_q;

  logic          fire_in, pop, allow_cfg, allow_cur, strip_now, release_now;
  logic          rel_in, tf_in;
  logic [2:0]    k_in;
  logic [CW-1:0] widx;

  assign in_ready    = cnt < CW'(DEPTH);
  assign fire_in     = in_valid & in_ready;
  assign pos_cur     = in_sof ? '0 : pos_q;
  assign allow_cfg   = cfg_strip_en & (|cfg_parse_depth) & ~(|cfg_l2_offset);
  assign allow_cur   = in_sof ? allow_cfg : allow_q;
  assign strip_now   = fire_in & (pos_cur == P_LAST) & allow_cur &
                       (type_h == TPID_H) & (type_l == TPID_L);
  assign release_now = fire_in & (in_eof | (pos_cur == P_LAST));
  assign k_in        = (pos_cur >= P_WIN && pos_cur <= P_LAST) ? 3'(pos_cur - PW'(10)) : 3'd0;
  assign rel_in      = (k_in == 3'd0) | release_now;
  assign tf_in       = strip_now | (~in_sof & frame_tag_q);

  assign pop         = (cnt != '0) & q_rel[0] & (q_drop[0] | out_ready);
  assign widx        = cnt - CW'(pop);

  assign out_valid      = (cnt != '0) & q_rel[0] & ~q_drop[0];
  assign out_data       = q_data[0];
  assign out_sof        = q_sof[0];
  assign out_eof        = q_eof[0];
  assign out_meta_valid = out_valid & q_eof[0];
  assign out_tag_found  = out_meta_valid & q_tf[0];
  assign out_tag_ctrl   = out_tag_found ? ctrl_q : 16'h0;

  always_comb begin
    m_data = q_data;
    m_k    = q_k;
    m_sof  = q_sof;
    m_eof  = q_eof;
    m_rel  = q_rel;
    m_drop = q_drop;
    m_tf   = q_tf;
    for (int i = 0; i < DEPTH; i++) begin
      if (release_now && CW'(i) < cnt) begin
        if (strip_now && q_k[i] == 3'd1) begin
          m_eof[i] = in_eof;
          m_tf[i]  = 1'b1;
        end else if (strip_now && q_k[i] != 3'd0) begin
          m_drop[i] = 1'b1;
        end
        m_rel[i] = 1'b1;
        m_k[i]   = 3'd0;
      end
    end

    n_data = m_data;
    n_k    = m_k;
    n_sof  = m_sof;
    n_eof  = m_eof;
    n_rel  = m_rel;
    n_drop = m_drop;
    n_tf   = m_tf;
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        n_data[i] = m_data[i+1];
        n_k[i]    = m_k[i+1];
        n_sof[i]  = m_sof[i+1];
        n_eof[i]  = m_eof[i+1];
        n_rel[i]  = m_rel[i+1];
        n_drop[i] = m_drop[i+1];
        n_tf[i]   = m_tf[i+1];
      end
    end

    if (fire_in) begin
      n_data[widx] = in_data;
      n_k[widx]    = release_now ? 3'd0 : k_in;
      n_sof[widx]  = in_sof;
      n_eof[widx]  = in_eof;
      n_rel[widx]  = rel_in;
      n_drop[widx] = strip_now;
      n_tf[widx]   = tf_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt         <= '0;
      q_sof       <= '0;
      q_eof       <= '0;
      q_rel       <= '0;
      q_drop      <= '0;
      q_tf        <= '0;
      pos_q       <= '0;
      allow_q     <= 1'b0;
      frame_tag_q <= 1'b0;
      type_h      <= '0;
      type_l      <= '0;
      ctrl_h      <= '0;
      ctrl_q      <= '0;
    end else begin
      cnt    <= cnt + CW'(fire_in) - CW'(pop);
      q_sof  <= n_sof;
      q_eof  <= n_eof;
      q_rel  <= n_rel;
      q_drop <= n_drop;
      q_tf   <= n_tf;
      if (fire_in) begin
        pos_q       <= in_eof ? '0 : ((pos_cur == P_SAT) ? P_SAT : pos_cur + PW'(1));
        frame_tag_q <= tf_in & ~in_eof;
        if (in_sof) allow_q <= allow_cfg;
        if (pos_cur == P_TYPEH) type_h <= in_data;
        if (pos_cur == P_TYPEL) type_l <= in_data;
        if (pos_cur == P_CTRLH) ctrl_h <= in_data;
        if (strip_now) ctrl_q <= {ctrl_h, in_data};
      end
    end
  end

  always_ff @(posedge clk) begin
    q_data <= n_data;
    q_k    <= n_k;
  end

endmodule

// File: rtl/vlan_tag_stripper_chk.sv
module vlan_tag_stripper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        out_valid,
  input logic        out_ready,
  input logic [7:0]  out_data,
  input logic        out_sof,
  input logic        out_eof,
  input logic        out_meta_valid,
  input logic        out_tag_found
);

  logic       o_busy;
  logic [7:0] o_cnt;
  logic       o_fire;

  assign o_fire = out_valid & out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_busy <= 1'b0;
      o_cnt  <= '0;
    end else if (o_fire) begin
      o_busy <= ~out_eof;
      o_cnt  <= out_eof ? 8'd0 : ((o_cnt == 8'hff) ? o_cnt : o_cnt + 8'd1);
    end
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eof))); // R10

  AST_META_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    out_meta_valid |-> (out_valid && out_eof)); // R5

  AST_SOF_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sof) |-> !o_busy); // R10

  AST_TAG_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (o_fire && out_tag_found) |-> (o_cnt >= 8'd11)); // R11

endmodule

bind vlan_tag_stripper vlan_tag_stripper_chk u_chk (.*);

// File: tb/vlan_tag_stripper_tb.sv
`timescale 1ns/1ps
module vlan_tag_stripper_tb;
  localparam int MAXF = 256;
  localparam int MAXB = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_strip_en = 1'b0;
  logic [1:0] cfg_parse_depth = '0;
  logic [4:0] cfg_l2_offset = '0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready;
  logic out_valid, out_sof, out_eof, out_meta_valid, out_tag_found;
  logic out_ready = 1'b1;
  logic [7:0] out_data;
  logic [15:0] out_tag_ctrl;

  always #2.5 clk = ~clk;

  vlan_tag_stripper u_dut (.*);

  logic [7:0]  fr [MAXF][MAXB];
  logic [7:0]  ex [MAXF][MAXB];
  int          flen [MAXF];
  int          elen [MAXF];
  bit          etf  [MAXF];
  logic [15:0] ectl [MAXF];
  bit          fen  [MAXF];
  logic [1:0]  fpd  [MAXF];
  logic [4:0]  fofs [MAXF];
  bit          fscr [MAXF];
  bit          fstl [MAXF];
  string       freq [MAXF];
  int nfr = 0, rfr = 0, checks = 0, fails = 0;
  bit in_gap = 0, out_gap = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic bit rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0] & lfsr[3];
  endfunction

  function automatic void add_frame(int len, int tpos, bit en, logic [1:0] pd,
                                    logic [4:0] ofs, bit scr, bit stl, string req);
    bit strip;
    int j;
    for (int i = 0; i < len; i++) fr[nfr][i] = 8'((i * 29) + (nfr * 7) + 3);
    if (len > 12 && fr[nfr][12] == 8'h81) fr[nfr][12] = 8'h08;
    if (tpos >= 0 && tpos + 1 < len) begin
      fr[nfr][tpos] = 8'h81;
      fr[nfr][tpos+1] = 8'h00;
    end
    strip = en && pd != 0 && ofs == 0 && len >= 16 &&
            fr[nfr][12] == 8'h81 && fr[nfr][13] == 8'h00;
    j = 0;
    for (int i = 0; i < len; i++)
      if (!(strip && i >= 12 && i <= 15)) begin
        ex[nfr][j] = fr[nfr][i];
        j++;
      end
    flen[nfr] = len; elen[nfr] = j; etf[nfr] = strip;
    ectl[nfr] = strip ? {fr[nfr][14], fr[nfr][15]} : 16'h0;
    fen[nfr] = en; fpd[nfr] = pd; fofs[nfr] = ofs;
    fscr[nfr] = scr; fstl[nfr] = stl; freq[nfr] = req;
    nfr++;
  endfunction

  task automatic send_all();
    for (int f = 0; f < nfr; f++) begin
      for (int i = 0; i < flen[f]; i++) begin
        @(negedge clk);
        in_gap = fstl[f];
        out_gap = fstl[f];
        while (in_gap && rnd()) begin
          in_valid = 1'b0;
          @(negedge clk);
        end
        if (i == 0) begin
          cfg_strip_en = fen[f]; cfg_parse_depth = fpd[f]; cfg_l2_offset = fofs[f];
        end else if (fscr[f]) begin
          cfg_strip_en = ~fen[f];
          cfg_parse_depth = (fpd[f] == 0) ? 2'd1 : 2'd0;
          cfg_l2_offset = (fofs[f] == 0) ? 5'd3 : 5'd0;
        end
        in_data = fr[f][i];
        in_sof = (i == 0);
        in_eof = (i == flen[f] - 1);
        in_valid = 1'b1;
        #1;
        while (!in_ready) begin
          @(negedge clk);
          #1;
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  logic [7:0] obuf [MAXB];
  int  ocnt = 0;
  bit  prev_stall = 0;
  logic [7:0] prev_data;
  bit  sof_bad = 0;

  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      out_ready = out_gap ? ~rnd() : 1'b1;
      #1;
      if (prev_stall) begin
        checks++;
        if (!(out_valid && out_data == prev_data)) begin
          fails++;
          $display("FAIL R10 stalled byte changed: valid=%0b data=%h expected valid=1 data=%h",
                   out_valid, out_data, prev_data);
        end
      end
      if (out_valid && out_ready) begin
        if (ocnt < MAXB) obuf[ocnt] = out_data;
        if (out_sof != (ocnt == 0)) sof_bad = 1;
        ocnt++;
        if (!out_eof && out_meta_valid) begin
          checks++; fails++;
          $display("FAIL R5 meta valid on non-last byte: got 1 expected 0");
        end
        if (out_eof) begin
          bit bad;
          bad = sof_bad || (ocnt != elen[rfr]);
          for (int i = 0; i < ocnt && i < MAXB; i++) if (obuf[i] != ex[rfr][i]) bad = 1;
          checks++;
          if (bad) begin
            fails++;
            $display("FAIL %s frame %0d: len got %0d expected %0d, first byte got %h expected %h",
                     freq[rfr], rfr, ocnt, elen[rfr], obuf[0], ex[rfr][0]);
          end
          checks++;
          if (out_meta_valid !== 1'b1 || out_tag_found !== etf[rfr] || out_tag_ctrl !== ectl[rfr]) begin
            fails++;
            $display("FAIL R5 (%s) frame %0d sideband: got v=%0b f=%0b c=%h expected v=1 f=%0b c=%h",
                     freq[rfr], rfr, out_meta_valid, out_tag_found, out_tag_ctrl, etf[rfr], ectl[rfr]);
          end
          rfr++;
          ocnt = 0;
          sof_bad = 0;
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data = out_data;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: frames got %0d expected %0d", rfr, nfr);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R10 reset state: out_valid=%0b in_ready=%0b expected 0 and 1", out_valid, in_ready);
    end
    rst_n = 1'b1;

    for (int len = 1; len <= 40; len++)
      add_frame(len, 12, 1, 2'd1, 5'd0, 0, 0, len < 16 ? "R7" : (len == 16 ? "R11" : "R2"));
    for (int len = 1; len <= 40; len++)
      add_frame(len, -1, 1, 2'd3, 5'd0, 0, 0, "R6");
    for (int e = 0; e < 2; e++)
      for (int p = 0; p < 4; p++)
        for (int o = 0; o < 3; o++) begin
          logic [4:0] ov;
          ov = (o == 0) ? 5'd0 : ((o == 1) ? 5'd1 : 5'd17);
          add_frame(20, 12, e[0], 2'(p), ov, 0, 0,
                    e == 0 ? "R1" : (p == 0 ? "R3" : (ov != 0 ? "R4" : "R2")));
          add_frame(16, 12, e[0], 2'(p), ov, 0, 0,
                    e == 0 ? "R1" : (p == 0 ? "R3" : (ov != 0 ? "R4" : "R11")));
        end
    for (int k = 0; k < 3; k++) begin
      add_frame(24 + k, 12, 1, 2'd2, 5'd0, 1, k[0], "R8");
      add_frame(24 + k, 12, 0, 2'd0, 5'd3, 1, k[0], "R8");
    end
    add_frame(24, 10, 1, 2'd1, 5'd0, 0, 0, "R9");
    add_frame(24, 14, 1, 2'd1, 5'd0, 0, 0, "R9");
    add_frame(24, 16, 1, 2'd1, 5'd0, 0, 0, "R9");
    add_frame(24, 0, 1, 2'd1, 5'd0, 0, 0, "R9");
    add_frame(24, 11, 1, 2'd1, 5'd0, 0, 1, "R9");
    for (int len = 12; len <= 36; len++) begin
      add_frame(len, 12, 1, 2'd1, 5'd0, 0, 1, "R10");
      add_frame(len, -1, 1, 2'd1, 5'd0, 0, 1, "R10");
    end
    for (int r = 0; r < 3; r++)
      for (int len = 1; len <= 5; len++)
        add_frame(len, -1, 1, 2'd1, 5'd0, 0, 1, "R10");
    add_frame(16, 12, 1, 2'd1, 5'd0, 0, 1, "R11");
    add_frame(17, 12, 1, 2'd1, 5'd0, 0, 1, "R2");

    send_all();
    while (rfr < nfr) @(negedge clk);
    repeat (4) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule